// File: doc/BRIEF.md
# Four-Channel Compare Timer

This block is a 16-bit timer with one shared counter and four compare channels. The counter runs in one of two ways. In modulo counting it climbs to a programmable limit and drops back to zero. In up/down counting it climbs to the limit and then descends to zero. On every counter tick, each enabled channel compares the count with its compare value. On a match the channel updates its output pin and, when allowed, latches an interrupt-pending flag. A single interrupt line reports whether any flag is pending.

A host programs the timer through a simple word-wide write/read port. Each channel has three control bits: enable, interrupt enable and immediate update. When immediate update is off, a compare write goes into a holding register. The new value becomes active only at the next point where the counter returns to zero, so a period in progress is never disturbed. A global enable and per-channel enables freeze the counting and channel logic without blocking register access. A separate stop input models a halted system clock and freezes everything.

In up/down counting a channel output rises at its up-slope match and falls at its down-slope match. Two channels with different compare values therefore give nested pulses, and the difference between the two compare values sets the gap on each side. This gives a programmable dead time between paired drive signals.

Top module: `mct_timer`

## Requirements
- R1: A channel's pending flag is set only when that channel matches while its interrupt-enable bit (channel control bit 1) is set. A match with that bit clear still moves the output but leaves the flag clear.
- R2: While the global enable (control register bit 0) is clear, the counter, the channel outputs and the pending flags do not change.
- R3: While a channel's enable bit (channel control bit 0) is clear, that channel's output, pending flag and compare registers stay as they are. The counter and the other channels keep running.
- R4: The register map is: 0 control (bit 0 global enable, bit 1 mode: 0 modulo, 1 up/down), 1 limit, 2 count (read only), 3 pending flags (one bit per channel). For channel n, address 4+2n is channel control and 5+2n is the compare value. Every writable register accepts writes and reads back while the global and channel enables are clear. Read data appears one clock after the address.
- R5: With a channel's update bit (channel control bit 2) set, a compare write becomes the active compare value at the next clock.
- R6: In modulo counting the count advances by one per tick from 0 to the limit and then returns to 0. A limit of 0xFFFF gives the full 16-bit range.
- R7: In up/down counting the count goes 0, 1, ..., limit, limit-1, ..., 1, 0, 1, ... with a period of twice the limit. Two channels with compare values a < b, both below the limit, give highs of 2*limit-2a and 2*limit-2b ticks per period. The second high lies inside the first.
- R8: While the stop input is high, no register changes, including host writes. Operation resumes from the same state when the stop input is released.
- R9: With the update bit clear, a compare write is held back. It becomes active at the tick that brings the counter to zero, while the timer and the channel are enabled. Until then, reading the compare address returns the old value.
- R10: Writing ones to the pending register clears the matching flags, and writing zeros has no effect. The interrupt output is high exactly while any flag is pending.
- R11: On a match, a channel output toggles in modulo counting. In up/down counting it is set by a match on the rising slope and cleared by a match on the falling slope.
- R12: Reset clears the counter, the control, limit, compare and holding registers, all enables and all pending flags, and drives the outputs and the interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_stop | input | 1 | Halts all activity while high |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW (4) | Register address |
| wdata | input | W (16) | Write data |
| rdata | output | W (16) | Registered read data |
| ch_out | output | NCH (4) | Channel outputs |
| irq | output | 1 | OR of all pending flags, registered |

## Verification
The bench sweeps limits from 1 to 5 in both counting modes, with every compare value, several tick counts and a different compare value on each channel. It checks the count, the four outputs and the pending flags against closed-form values. An off-by-one at the turn points would show up as a wrong final count: a counter that lingers at the limit or at zero, or one that wraps one value early. A wrong slope decision would leave up/down outputs in the wrong state. Directed runs catch a compare write that skips the holding register, and a disabled channel or a cleared interrupt enable that still raises a flag. They also catch a stop input that lets a host write through, and a pending clear that also clears flags written as zero. A pulse-width measurement in up/down counting catches a nested pair whose widths or overlap come out wrong.

// File: rtl/mct_pkg.sv
package mct_pkg;

  typedef enum logic {
    CNT_MODULO = 1'b0,
    CNT_UPDOWN = 1'b1
  } cnt_mode_e;

  // register addresses
  localparam int ADR_CTRL    = 0;
  localparam int ADR_RELOAD  = 1;
  localparam int ADR_COUNT   = 2;
  localparam int ADR_PEND    = 3;
  localparam int ADR_CH_BASE = 4;

  // channel control bit positions
  localparam int CTL_EN = 0;
  localparam int CTL_IE = 1;
  localparam int CTL_UE = 2;

  function automatic int ch_ctl_adr(input int ch);
    return ADR_CH_BASE + 2 * ch;
  endfunction

  function automatic int ch_cmp_adr(input int ch);
    return ADR_CH_BASE + 2 * ch + 1;
  endfunction

endpackage

// File: rtl/mct_counter.sv
module mct_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic         ud,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         zero_ld
);

  logic [W-1:0] cnt_d;
  logic         up_d;

  always_comb begin
    cnt_d = cnt;
    up_d  = up;
    if (!ud) begin
      up_d = 1'b1;
      if (cnt >= reload) cnt_d = '0;
      else               cnt_d = cnt + W'(1);
    end else if (reload == '0) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (up) begin
      if (cnt >= reload) begin
        cnt_d = cnt - W'(1);
        up_d  = 1'b0;
      end else begin
        cnt_d = cnt + W'(1);
      end
    end else begin
      if (cnt == '0) begin
        cnt_d = W'(1);
        up_d  = 1'b1;
      end else begin
        cnt_d = cnt - W'(1);
      end
    end
  end

  // strobe for shadow-to-active transfer: this tick lands on zero
  assign zero_ld = adv && (cnt_d == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (adv) begin
      cnt <= cnt_d;
      up  <= up_d;
    end
  end

endmodule

// File: rtl/mct_channel.sv
module mct_channel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         act,
  input  logic [W-1:0] cnt,
  input  logic         up,
  input  logic         ud,
  input  logic         zero_ld,
  input  logic         ie,
  input  logic         ue,
  input  logic         wr_cmp,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cmp_act,
  output logic         out,
  output logic         hit
);

  logic [W-1:0] cmp_shd;
  logic         match;

  assign match = act && (cnt == cmp_act);
  assign hit   = match && ie;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_act <= '0;
      cmp_shd <= '0;
      out     <= 1'b0;
    end else begin
      if (act && zero_ld && !ue) cmp_act <= cmp_shd;
      if (wr_cmp) begin
        if (ue) cmp_act <= wdata;
        else    cmp_shd <= wdata;
      end
      if (match) out <= ud ? up : ~out;
    end
  end

endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter  int NCH = 4,
  parameter  int W   = 16,
  localparam int AW  = $clog2(ADR_CH_BASE + 2 * NCH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clk_stop,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [W-1:0]   wdata,
  output logic [W-1:0]   rdata,
  output logic [NCH-1:0] ch_out,
  output logic           irq
);

  logic            gen_q;
  cnt_mode_e       mode_q;
  logic [W-1:0]    reload_q;
  logic [W-1:0]    cnt_q;
  logic            up_q;
  logic            zero_ld;
  logic            we, run, ud;
  logic [NCH-1:0]  ch_en_q, ie_q, ue_q, hit;
  logic [NCH-1:0]  pend_q, pend_d, clr;
  logic [W-1:0]    cmp_act [NCH];
  logic [W-1:0]    rd_mux;
  logic [W-1:0]    rdata_q;
  logic            irq_q;

  assign we  = wr_en & ~clk_stop;
  assign run = gen_q & ~clk_stop;
  assign ud  = (mode_q == CNT_UPDOWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      gen_q    <= 1'b0;
      mode_q   <= CNT_MODULO;
      reload_q <= '0;
    end else if (we) begin
      if (addr == AW'(ADR_CTRL)) begin
        gen_q  <= wdata[0];
        mode_q <= cnt_mode_e'(wdata[1]);
      end
      if (addr == AW'(ADR_RELOAD)) reload_q <= wdata;
    end
  end

  mct_counter #(.W(W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .adv     (run),
    .ud      (ud),
    .reload  (reload_q),
    .cnt     (cnt_q),
    .up      (up_q),
    .zero_ld (zero_ld)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [AW-1:0] CTL_A = AW'(ch_ctl_adr(i));
    localparam logic [AW-1:0] CMP_A = AW'(ch_cmp_adr(i));
    logic en_r, ie_r, ue_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_r <= 1'b0;
        ie_r <= 1'b0;
        ue_r <= 1'b0;
      end else if (we && addr == CTL_A) begin
        en_r <= wdata[CTL_EN];
        ie_r <= wdata[CTL_IE];
        ue_r <= wdata[CTL_UE];
      end
    end

    assign ch_en_q[i] = en_r;
    assign ie_q[i]    = ie_r;
    assign ue_q[i]    = ue_r;

    mct_channel #(.W(W)) u_chan (
      .clk     (clk),
      .rst     (rst),
      .act     (run & en_r),
      .cnt     (cnt_q),
      .up      (up_q),
      .ud      (ud),
      .zero_ld (zero_ld),
      .ie      (ie_r),
      .ue      (ue_r),
      .wr_cmp  (we && addr == CMP_A),
      .wdata   (wdata),
      .cmp_act (cmp_act[i]),
      .out     (ch_out[i]),
      .hit     (hit[i])
    );
  end

  always_comb begin
    clr = '0;
    if (we && addr == AW'(ADR_PEND)) clr = wdata[NCH-1:0];
    pend_d = (pend_q & ~clr) | hit;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      AW'(ADR_CTRL):   rd_mux = W'({mode_q == CNT_UPDOWN, gen_q});
      AW'(ADR_RELOAD): rd_mux = reload_q;
      AW'(ADR_COUNT):  rd_mux = cnt_q;
      AW'(ADR_PEND):   rd_mux = W'(pend_q);
      default:         rd_mux = '0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(ch_ctl_adr(i))) rd_mux = W'({ue_q[i], ie_q[i], ch_en_q[i]});
      if (addr == AW'(ch_cmp_adr(i))) rd_mux = cmp_act[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else if (!clk_stop) begin
      pend_q  <= pend_d;
      irq_q   <= |pend_d;
      rdata_q <= rd_mux;
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
  parameter int NCH = 4,
  parameter int W   = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           clk_stop,
  input logic           gen,
  input logic           ud,
  input logic [W-1:0]   reload,
  input logic [W-1:0]   cnt,
  input logic           up,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] ie,
  input logic [NCH-1:0] pend,
  input logic [NCH-1:0] ch_out,
  input logic           irq
);

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
    clk_stop |=> $stable(cnt) && $stable(ch_out) && $stable(pend) && $stable(reload)); // R8

  AST_GLOBAL_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !gen |=> $stable(cnt) && $stable(ch_out) && $stable(up)); // R2

  AST_MODULO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (gen && !clk_stop && !ud && cnt >= reload) |=> (cnt == '0)); // R6

  AST_UPDOWN_TURN: assert property (@(posedge clk) disable iff (rst)
    (gen && !clk_stop && ud && reload != '0 && up && cnt == reload)
      |=> (cnt == reload - W'(1)) && !up); // R7

  AST_IRQ_ANY_PEND: assert property (@(posedge clk) disable iff (rst)
    irq == (|pend)); // R10

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    AST_PEND_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
      $rose(pend[i]) |-> $past(ie[i])); // R1

    AST_CH_OFF_HOLD: assert property (@(posedge clk) disable iff (rst)
      !ch_en[i] |=> $stable(ch_out[i])); // R3
  end

endmodule

bind mct_timer mct_timer_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clk_stop (clk_stop),
  .gen      (gen_q),
  .ud       (ud),
  .reload   (reload_q),
  .cnt      (cnt_q),
  .up       (up_q),
  .ch_en    (ch_en_q),
  .ie       (ie_q),
  .pend     (pend_q),
  .ch_out   (ch_out),
  .irq      (irq)
);

// File: tb/mct_timer_test.sv
module mct_timer_test;
  import mct_pkg::*;

  localparam int NCH  = 4;
  localparam int W    = 16;
  localparam int AW   = $clog2(ADR_CH_BASE + 2 * NCH);
  localparam int HALF = 10; // time unit taken as 1 ns: 50 MHz

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           clk_stop = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  addr = '0;
  logic [W-1:0]   wdata = '0;
  logic [W-1:0]   rdata;
  logic [NCH-1:0] ch_out;
  logic           irq;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  always #HALF clk = ~clk;

  mct_timer #(.NCH(NCH), .W(W)) uut (
    .clk(clk), .rst(rst), .clk_stop(clk_stop), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ch_out(ch_out), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic reg_wr(input int a, input logic [W-1:0] d);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [W-1:0] d);
    addr = AW'(a);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_ticks(input int n, input bit u);
    reg_wr(ADR_CTRL, W'({u, 1'b1}));
    repeat (n - 1) @(negedge clk);
    reg_wr(ADR_CTRL, W'({u, 1'b0}));
  endtask

  function automatic int tri_pos(input int r, input int k);
    int m;
    m = k % (2 * r);
    return (m <= r) ? m : 2 * r - m;
  endfunction

  function automatic int count_after(input bit u, input int r, input int n);
    return u ? tri_pos(r, n) : n % (r + 1);
  endfunction

  // returns {hit, out} for one channel after n ticks
  function automatic logic [1:0] chan_after(input bit u, input int r, input int c, input int n);
    logic o, h;
    int v, m;
    bit rising;
    o = 1'b0; h = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (u) begin
        m = k % (2 * r);
        v = tri_pos(r, k);
        rising = (k == 0) || (m >= 1 && m <= r);
      end else begin
        v = k % (r + 1);
        rising = 1'b1;
      end
      if (v == c) begin
        h = 1'b1;
        o = u ? rising : ~o;
      end
    end
    return {h, o};
  endfunction

  task automatic finish_up();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    logic [W-1:0] rv;
    logic [NCH-1:0] exp_out, exp_pend;
    logic [1:0] cr;
    int hi0, hi1, bad_nest;

    @(negedge clk);
    do_reset();

    // R12 reset state
    check("R12 ch_out", ch_out, 0);
    check("R12 irq", irq, 0);
    reg_rd(ADR_COUNT, rv);        check("R12 count", rv, 0);
    reg_rd(ADR_CTRL, rv);         check("R12 ctrl", rv, 0);
    reg_rd(ch_cmp_adr(3), rv);    check("R12 cmp3", rv, 0);
    reg_rd(ADR_PEND, rv);         check("R12 pend", rv, 0);

    // R4 access while disabled, R5 immediate compare update
    reg_wr(ADR_RELOAD, 16'hFFFF);
    reg_rd(ADR_RELOAD, rv);       check("R4 limit readback", rv, 16'hFFFF);
    reg_wr(ch_ctl_adr(1), 16'h4);
    reg_rd(ch_ctl_adr(1), rv);    check("R4 chctl readback", rv, 4);
    reg_wr(ch_cmp_adr(1), 16'h1234);
    reg_rd(ch_cmp_adr(1), rv);    check("R5 immediate compare", rv, 16'h1234);

    // R6 full range: 0xFFFF limit, count does not wrap early
    run_ticks(300, 1'b0);
    reg_rd(ADR_COUNT, rv);        check("R6 full-range count", rv, 300);

    // R6 R7 R11 R1 sweep
    for (int u = 0; u < 2; u++) begin
      for (int r = 1; r <= 5; r++) begin
        for (int c = 0; c <= r; c++) begin
          for (int t = 0; t < 3; t++) begin
            int n;
            n = (t == 0) ? r + 1 : (t == 1) ? 2 * r + 3 : 4 * r + 1;
            do_reset();
            reg_wr(ADR_RELOAD, W'(r));
            for (int j = 0; j < NCH; j++) begin
              reg_wr(ch_ctl_adr(j), 16'h7);
              reg_wr(ch_cmp_adr(j), W'((c + j) % (r + 1)));
            end
            run_ticks(n, u[0]);
            for (int j = 0; j < NCH; j++) begin
              cr = chan_after(u[0], r, (c + j) % (r + 1), n);
              exp_out[j]  = cr[0];
              exp_pend[j] = cr[1];
            end
            reg_rd(ADR_COUNT, rv);
            check(u ? "R7 updown count" : "R6 modulo count", rv, count_after(u[0], r, n));
            check(u ? "R11 updown outputs" : "R11 modulo outputs", ch_out, exp_out);
            reg_rd(ADR_PEND, rv);
            check("R1 pending after sweep", rv, exp_pend);
          end
        end
      end
    end

    // R9 holding register with update bit clear
    do_reset();
    reg_wr(ADR_RELOAD, 4);
    reg_wr(ch_ctl_adr(0), 16'h1);
    reg_wr(ch_cmp_adr(0), 3);
    reg_rd(ch_cmp_adr(0), rv);    check("R9 held before run", rv, 0);
    run_ticks(4, 1'b0);
    reg_rd(ch_cmp_adr(0), rv);    check("R9 held before wrap", rv, 0);
    run_ticks(1, 1'b0);
    reg_rd(ch_cmp_adr(0), rv);    check("R9 active after wrap", rv, 3);

    // R1 R3 interrupt enable and channel enable
    do_reset();
    reg_wr(ADR_RELOAD, 5);
    reg_wr(ch_ctl_adr(0), 16'h5);  reg_wr(ch_cmp_adr(0), 2);
    reg_wr(ch_ctl_adr(1), 16'h6);  reg_wr(ch_cmp_adr(1), 2);
    reg_wr(ch_ctl_adr(2), 16'h7);  reg_wr(ch_cmp_adr(2), 2);
    run_ticks(6, 1'b0);
    check("R3 disabled channel output", ch_out, 4'b0101);
    reg_rd(ADR_PEND, rv);         check("R1 flag needs enable", rv, 4'b0100);
    check("R10 irq set", irq, 1);

    // R10 write-one-to-clear
    reg_wr(ADR_PEND, 16'h0);
    reg_rd(ADR_PEND, rv);         check("R10 zero write keeps", rv, 4'b0100);
    reg_wr(ADR_PEND, 16'h4);
    check("R10 irq cleared", irq, 0);
    reg_rd(ADR_PEND, rv);         check("R10 flag cleared", rv, 0);

    // R8 stop input freezes all, including writes
    do_reset();
    reg_wr(ADR_RELOAD, 9);
    reg_wr(ADR_CTRL, 16'h1);
    clk_stop = 1'b1;
    reg_wr(ADR_RELOAD, 2);
    repeat (6) @(negedge clk);
    clk_stop = 1'b0;
    repeat (2) @(negedge clk);
    reg_wr(ADR_CTRL, 16'h0);
    reg_rd(ADR_COUNT, rv);        check("R8 count excludes stop", rv, 3);
    reg_rd(ADR_RELOAD, rv);       check("R8 write ignored", rv, 9);

    // R2 global enable off holds count
    repeat (10) @(negedge clk);
    reg_rd(ADR_COUNT, rv);        check("R2 count held", rv, 3);

    // R7 nested pulses in up/down counting
    do_reset();
    reg_wr(ADR_RELOAD, 8);
    reg_wr(ch_ctl_adr(0), 16'h5);  reg_wr(ch_cmp_adr(0), 2);
    reg_wr(ch_ctl_adr(1), 16'h5);  reg_wr(ch_cmp_adr(1), 5);
    reg_wr(ADR_CTRL, 16'h3);
    repeat (40) @(negedge clk);
    hi0 = 0; hi1 = 0; bad_nest = 0;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      if (ch_out[0]) hi0++;
      if (ch_out[1]) hi1++;
      if (ch_out[1] && !ch_out[0]) bad_nest++;
    end
    reg_wr(ADR_CTRL, 16'h2);
    check("R7 outer pulse width", hi0, 12);
    check("R7 inner pulse width", hi1, 6);
    check("R7 inner nested in outer", bad_nest, 0);

    done = 1'b1;
    finish_up();
  end

endmodule